// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Event Detector

This block watches every input line of a GPIO bank and turns a chosen kind of activity into a pending interrupt bit. Each line has its own 3-bit event code. The code picks one of five triggers: a falling edge, a rising edge, either edge, a low level or a high level. The codes come from configuration storage that lives outside the block. The inputs pass through a synchroniser. Edges are found by comparing the synchronised value with the value it had one clock earlier.

Pending events collect in a status word. Reading that word returns it and empties it in the same access, so no separate acknowledge exists. A mask word decides which pending bits reach the single bank interrupt output. Software never writes the mask directly. Ones written to a set-port turn mask bits on, and ones written to a clear-port turn them off. Status bits are captured whether or not their line is masked.

Top module: `gpio_evt_bank`

## Requirements
- R1: Event code 0 (falling edge) sets a line's status bit when the synchronised input goes from 1 to 0, and not when it goes from 0 to 1.
- R2: Event code 1 (rising edge) sets a line's status bit when the synchronised input goes from 0 to 1, and not when it goes from 1 to 0.
- R3: Event code 2 sets a line's status bit on both a 0-to-1 and a 1-to-0 change of the synchronised input.
- R4: Event code 3 (low level) sets the status bit on every cycle that the synchronised input is 0, so the bit comes back right after a read while the level holds. It stops once the input is 1.
- R5: Event code 4 (high level) sets the status bit on every cycle that the synchronised input is 1, and stops once the input is 0.
- R6: Event codes 5, 6 and 7 are reserved and never set a status bit, whatever the input does.
- R7: A write to byte offset 0x20 sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 are left unchanged.
- R8: A write to byte offset 0x24 clears each mask bit whose data bit is 1 and leaves the others. Offset 0x28 returns the mask when read, and writes to 0x28 have no effect.
- R9: A read at byte offset 0x2C returns the pending status word and clears it at that clock edge, so a second read with no new events returns 0.
- R10: An event that is detected in the same cycle as a status read is set after that read and shows up on the next read.
- R11: `irq_o` is 1 exactly when at least one bit is set in both status and mask.
- R12: An input change driven between two clock edges reaches the status bit (and `irq_o`) at the third rising edge after the change, and not at the second.
- R13: Status bits are captured for lines whose mask bit is 0. Enabling the mask later raises `irq_o` for the pending event.
- R14: After reset the mask and the status are 0 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_LINES | Raw asynchronous line inputs |
| evt_sel_i | input | 3*NUM_LINES | Event code per line; line k uses bits [3k+2:3k] |
| bus_wr_i | input | 1 | Register write strobe for one cycle |
| bus_rd_i | input | 1 | Register read strobe; a status read clears at this edge |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | NUM_LINES | Write data |
| bus_rdata_o | output | NUM_LINES | Read data, combinational from the address |
| irq_o | output | 1 | Combined bank interrupt |

## Verification
On every cycle, the assertions check the mask update rules and the status rules. Set-port writes turn on the written bits, clear-port writes turn them off, and the mask holds its value when neither port is written. Detected events always land in status, bits stay until a read, and a read leaves only newly detected events. Reserved codes never produce a detection, and a set-port write that covers a pending bit raises the interrupt. Only the bench scenarios can show the meaning of each event code at the pins and the exact three-edge latency. They also cover a read landing on the same edge as an event, and levels re-arming after a read.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic [2:0] {
    EVT_FALL = 3'd0,
    EVT_RISE = 3'd1,
    EVT_BOTH = 3'd2,
    EVT_LOW  = 3'd3,
    EVT_HIGH = 3'd4
  } evt_code_e;

  localparam int OFS_MASK_SET = 'h20;
  localparam int OFS_MASK_CLR = 'h24;
  localparam int OFS_MASK_RD  = 'h28;
  localparam int OFS_STATUS   = 'h2C;

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int NUM_LINES = 32,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  output logic [NUM_LINES-1:0] now_o,
  output logic [NUM_LINES-1:0] prev_o
);

  logic [STAGES-1:0][NUM_LINES-1:0] chain_q, chain_d;
  logic [NUM_LINES-1:0]             prev_q, prev_d;

  always_comb begin
    chain_d[0] = pin_i;
    prev_d     = chain_q[STAGES-1];
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_comb chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign now_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic [NUM_LINES-1:0]   now_i,
  input  logic [NUM_LINES-1:0]   prev_i,
  input  logic [3*NUM_LINES-1:0] sel_i,
  output logic [NUM_LINES-1:0]   hit_o
);

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    logic       rise, fall;
    logic [2:0] code;
    assign code = sel_i[3*k +: 3];
    assign rise = now_i[k] & ~prev_i[k];
    assign fall = ~now_i[k] & prev_i[k];

    always_comb begin
      unique case (code)
        EVT_FALL: hit_o[k] = fall;
        EVT_RISE: hit_o[k] = rise;
        EVT_BOTH: hit_o[k] = rise | fall;
        EVT_LOW:  hit_o[k] = ~now_i[k];
        EVT_HIGH: hit_o[k] = now_i[k];
        default:  hit_o[k] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
  import gpio_evt_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [NUM_LINES-1:0] bus_wdata_i,
  input  logic [NUM_LINES-1:0] hit_i,
  output logic [NUM_LINES-1:0] bus_rdata_o,
  output logic                 irq_o
);

  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_MASK_CLR);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK_RD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);

  logic [NUM_LINES-1:0] mask_q, mask_d, stat_q, stat_d;
  logic                 set_stb, clr_stb, stat_rd, mask_en, stat_en;

  always_comb begin
    set_stb = bus_wr_i && (bus_addr_i == A_SET);
    clr_stb = bus_wr_i && (bus_addr_i == A_CLR);
    stat_rd = bus_rd_i && (bus_addr_i == A_STAT);
    mask_en = set_stb | clr_stb;
    stat_en = stat_rd | (|hit_i);
    mask_d  = mask_q;
    if (set_stb) mask_d = mask_d | bus_wdata_i;
    if (clr_stb) mask_d = mask_d & ~bus_wdata_i;
    stat_d  = (stat_rd ? '0 : stat_q) | hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_MASK) bus_rdata_o = mask_q;
    if (bus_addr_i == A_STAT) bus_rdata_o = stat_q;
  end

  assign irq_o = |(stat_q & mask_q);

  p_set_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((mask_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  p_clr_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((mask_q & $past(bus_wdata_i)) == '0));

  p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_i && (bus_addr_i == A_SET || bus_addr_i == A_CLR)) |=> $stable(mask_q));

  p_hit_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((stat_q & ~$past(hit_i)) == '0));

  p_enable_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !stat_rd && (|(bus_wdata_i & stat_q))) |=> irq_o);

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_LINES-1:0]   pin_i,
  input  logic [3*NUM_LINES-1:0] evt_sel_i,
  input  logic                   bus_wr_i,
  input  logic                   bus_rd_i,
  input  logic [ADDR_W-1:0]      bus_addr_i,
  input  logic [NUM_LINES-1:0]   bus_wdata_i,
  output logic [NUM_LINES-1:0]   bus_rdata_o,
  output logic                   irq_o
);

  logic [NUM_LINES-1:0] now_w, prev_w, hit_w;

  gpio_evt_sync #(.NUM_LINES(NUM_LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .now_o  (now_w),
    .prev_o (prev_w)
  );

  gpio_evt_detect #(.NUM_LINES(NUM_LINES)) i_detect (
    .now_i  (now_w),
    .prev_i (prev_w),
    .sel_i  (evt_sel_i),
    .hit_o  (hit_w)
  );

  gpio_evt_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .hit_i       (hit_w),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o)
  );

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_chk
    p_rsvd_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_sel_i[3*k +: 3] > 3'd4) |-> !hit_w[k]);
  end

endmodule

// File: tb/test_gpio_evt_bank.sv
module test_gpio_evt_bank;

  localparam int  N      = 32;
  localparam int  AW     = 6;
  localparam time CLK_PD = 10ns;

  localparam logic [AW-1:0] A_SET  = 6'h20;
  localparam logic [AW-1:0] A_CLR  = 6'h24;
  localparam logic [AW-1:0] A_MASK = 6'h28;
  localparam logic [AW-1:0] A_STAT = 6'h2C;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pins = '0;
  logic [3*N-1:0] sel;
  logic           bwr = 1'b0, brd = 1'b0;
  logic [AW-1:0]  baddr = '0;
  logic [N-1:0]   bwdata = '0;
  logic [N-1:0]   brdata;
  logic           irq;

  int  n_chk = 0, n_bad = 0;
  bit  done = 0;

  gpio_evt_bank #(.NUM_LINES(N), .SYNC_STAGES(2), .ADDR_W(AW)) i_gpio_evt_bank (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .evt_sel_i(sel),
    .bus_wr_i(bwr), .bus_rd_i(brd), .bus_addr_i(baddr),
    .bus_wdata_i(bwdata), .bus_rdata_o(brdata), .irq_o(irq)
  );

  always #(CLK_PD/2) clk = ~clk;

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk); bwr = 1'b1; baddr = a; bwdata = d;
    @(posedge clk); #1 bwr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] v);
    @(negedge clk); brd = 1'b1; baddr = a;
    #1 v = brdata;
    @(posedge clk); #1 brd = 1'b0;
  endtask

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic all_sel(input logic [2:0] c);
    @(negedge clk);
    for (int k = 0; k < N; k++) sel[3*k +: 3] = c;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    #1 check("R14 irq after reset", {31'd0, irq}, '0);
    rd(A_MASK, v); check("R14 mask after reset", v, '0);
    rd(A_STAT, v); check("R14 status after reset", v, '0);
  endtask

  task automatic t_mask();
    logic [N-1:0] v;
    wr(A_SET, 32'h0000_00F5);  rd(A_MASK, v); check("R7 set ones", v, 32'h0000_00F5);
    wr(A_SET, 32'h0000_0100);  rd(A_MASK, v); check("R7 zeros keep", v, 32'h0000_01F5);
    wr(A_CLR, 32'h0000_0011);  rd(A_MASK, v); check("R8 clear ones", v, 32'h0000_01E4);
    wr(A_MASK, 32'hFFFF_FFFF); rd(A_MASK, v); check("R8 mask write ignored", v, 32'h0000_01E4);
    wr(A_CLR, 32'hFFFF_FFFF);  rd(A_MASK, v); check("R8 clear all", v, '0);
  endtask

  task automatic t_edges();
    logic [N-1:0] v;
    all_sel(3'd5);
    @(negedge clk);
    sel[0 +: 3] = 3'd0; sel[3 +: 3] = 3'd1; sel[6 +: 3] = 3'd2;
    sel[15 +: 3] = 3'd5; sel[18 +: 3] = 3'd6; sel[21 +: 3] = 3'd7;
    rd(A_STAT, v);
    set_pins(32'h0000_00E7); wait_cyc(4);
    rd(A_STAT, v); check("R2 R3 R6 rising edges", v, 32'h0000_0006);
    rd(A_STAT, v); check("R9 read cleared", v, '0);
    set_pins('0); wait_cyc(4);
    rd(A_STAT, v); check("R1 R3 R6 falling edges", v, 32'h0000_0005);
  endtask

  task automatic t_levels();
    logic [N-1:0] v;
    all_sel(3'd5);
    set_pins(32'h0000_0008); wait_cyc(4);
    @(negedge clk); sel[9 +: 3] = 3'd3; sel[12 +: 3] = 3'd4;
    wait_cyc(2);
    rd(A_STAT, v); check("R4 R5 inactive levels", v, '0);
    set_pins(32'h0000_0010); wait_cyc(4);
    rd(A_STAT, v); check("R4 R5 active levels", v, 32'h0000_0018);
    rd(A_STAT, v); check("R4 level re-sets after read", v, 32'h0000_0018);
    set_pins(32'h0000_0008); wait_cyc(4);
    rd(A_STAT, v); check("R5 leftover before release", v, 32'h0000_0018);
    rd(A_STAT, v); check("R4 R5 released", v, '0);
  endtask

  task automatic t_collide();
    logic [N-1:0] v;
    all_sel(3'd5);
    set_pins('0); wait_cyc(4);
    @(negedge clk); sel[3 +: 3] = 3'd1;
    rd(A_STAT, v);
    @(negedge clk); pins = 32'h0000_0002;
    @(posedge clk); @(posedge clk);
    @(negedge clk); brd = 1'b1; baddr = A_STAT;
    #1 check("R10 not yet pending", brdata, '0);
    @(posedge clk); #1 brd = 1'b0;
    rd(A_STAT, v); check("R10 event at read kept", v, 32'h0000_0002);
  endtask

  task automatic t_irq();
    logic [N-1:0] v;
    set_pins('0); wait_cyc(4);
    rd(A_STAT, v);
    wr(A_SET, 32'h0000_0002);
    @(negedge clk); pins = 32'h0000_0002;
    @(posedge clk); @(posedge clk); #1
    check("R12 not at second edge", {31'd0, irq}, '0);
    @(posedge clk); #1
    check("R12 at third edge", {31'd0, irq}, 32'd1);
    wr(A_CLR, 32'h0000_0002); check("R11 masked off", {31'd0, irq}, '0);
    rd(A_STAT, v);
    set_pins('0); wait_cyc(4);
    set_pins(32'h0000_0002); wait_cyc(4);
    #1 check("R13 masked no irq", {31'd0, irq}, '0);
    wr(A_SET, 32'h0000_0004); check("R11 other bit no irq", {31'd0, irq}, '0);
    wr(A_SET, 32'h0000_0002); check("R13 pending then enabled", {31'd0, irq}, 32'd1);
    rd(A_STAT, v); check("R13 status kept while masked", v, 32'h0000_0002);
    #1 check("R11 irq drops after read", {31'd0, irq}, '0);
  endtask

  initial begin
    for (int k = 0; k < N; k++) sel[3*k +: 3] = 3'd1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_mask();
    t_edges();
    t_levels();
    t_collide();
    t_irq();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule